// File: doc/BRIEF.md
# External Memory Bus Controller

This block connects an on-chip requester to an asynchronous SRAM-style memory bus. The requester presents an address, write data, a read/write flag, a flag that picks program or data space, and a valid pulse. The controller then runs one external cycle. It drives the address, pulls the select for the chosen space low, and pulses either the read or the write strobe low. It holds that strobe for a programmable number of extra wait cycles.

Write data goes onto the bus while a write is in progress. Read data is latched when the read strobe rises and is handed back with a one-cycle ready pulse. In all other cycles the data bus is released.

Each access has the same shape:
- one setup cycle, in which the address and select are valid and the strobes are high;
- the strobe phase;
- one hold cycle, in which the strobe is high again, the select is still low and ready is raised.

A new request may be presented in the cycle right after ready, so accesses can run back to back.

Top module: `xmem_bridge`

## Requirements
- R1: While reset is asserted, and right after it, `progSelN`, `dataSelN`, `rdStrobeN` and `wrStrobeN` are all high, `busDataOe` is low and `reqReady` is low.
- R2: A program-space access (`reqProgSpace`=1) pulls only `progSelN` low. A data-space access (`reqProgSpace`=0) pulls only `dataSelN` low. The two selects are never low together.
- R3: During an access the select and `busAddr` stay valid and unchanged, and equal to the requested address, from the setup cycle through the hold cycle. This covers every cycle in which a strobe is low.
- R4: A write (`reqWrite`=1) pulses only `wrStrobeN`. It keeps `busDataOe` high with `busDataOut` equal to the write data for the whole access, including the cycle after the strobe rises. The value present at the strobe's rising edge is what lands in memory.
- R5: A read (`reqWrite`=0) pulses only `rdStrobeN` and keeps `busDataOe` low. `rspRdata` returns the bus value captured at the clock edge on which `rdStrobeN` rises.
- R6: The 2-bit `waitSel` field encodes the extra wait cycles as 00=0, 01=4, 10=8, 11=12. The active strobe stays low for 1 + that number of consecutive cycles.
- R7: `reqReady` is a single-cycle pulse that occurs while both strobes are high, in the cycle right after the strobe rises. It comes waitcycles+3 cycles after the accepting clock edge.
- R8: Whenever both selects are high (no access in progress), `busDataOe` is low.
- R9: The request fields and `waitSel` are sampled only at the accepting edge, so changing them afterwards does not affect the access. A request raised in the cycle after `reqReady` is accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when the controller is idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqProgSpace | input | 1 | 1 = program space, 0 = data space |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| waitSel | input | WSEL_W | Wait-state code (00/01/10/11 = 0/4/8/12 cycles) |
| reqReady | output | 1 | One-cycle completion pulse |
| rspRdata | output | DATA_W | Captured read data, valid with reqReady |
| busAddr | output | ADDR_W | External address |
| busDataOut | output | DATA_W | Value for the data pads when driven |
| busDataOe | output | 1 | Pad output enable; 0 = bus released |
| busDataIn | input | DATA_W | Value seen on the data pads |
| progSelN | output | 1 | Program space select, active low |
| dataSelN | output | 1 | Data space select, active low |
| rdStrobeN | output | 1 | Read strobe, active low |
| wrStrobeN | output | 1 | Write strobe, active low |

## Verification
The bench uses the default parameters: 16-bit address and data, a 2-bit wait code and a step of 4. With these, every wait setting (strobe lengths of 1, 5, 9 and 13 cycles) and both address extremes 0x0000 and 0xFFFF are reachable in short runs.

A bench-side memory model keeps program and data space apart. It stores on the rising edge of the write strobe and answers reads only while the read strobe is low. As a result, a wrong space, address, data value or capture edge shows up as a read-back mismatch.

Changing `waitSel` right after acceptance, and issuing requests in the cycle after `reqReady`, exercise the sampling and back-to-back rules.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETUP  = 2'd1,
    SQ_STROBE = 2'd2,
    SQ_HOLD   = 2'd3
  } seqState_t;

  // Active-high controls, derived from the next sequencer state;
  // the datapath registers them onto the pins.
  typedef struct packed {
    logic progSel;
    logic dataSel;
    logic rdStb;
    logic wrStb;
    logic driveBus;
    logic latchReq;
    logic captureRd;
    logic ready;
  } busCtl_t;

endpackage

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int WSEL_W    = 2,
  parameter int WAIT_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqProgSpace,
  input  logic [WSEL_W-1:0] waitSel,
  output busCtl_t           ctl
);

  localparam int MAX_WAIT = ((2 ** WSEL_W) - 1) * WAIT_STEP;
  localparam int CNT_W    = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT + 1);

  seqState_t        state, nextState;
  logic             isWrite, isProg, nxtWrite, nxtProg;
  logic [CNT_W-1:0] waitCnt, nxtCnt;
  logic             accept;

  always_comb begin
    nextState = state;
    nxtWrite  = isWrite;
    nxtProg   = isProg;
    nxtCnt    = waitCnt;
    accept    = 1'b0;
    unique case (state)
      SQ_IDLE: begin
        if (reqValid) begin
          accept    = 1'b1;
          nextState = SQ_SETUP;
          nxtWrite  = reqWrite;
          nxtProg   = reqProgSpace;
          nxtCnt    = CNT_W'(int'(waitSel) * WAIT_STEP);
        end
      end
      SQ_SETUP: nextState = SQ_STROBE;
      SQ_STROBE: begin
        if (waitCnt == '0) nextState = SQ_HOLD;
        else               nxtCnt    = waitCnt - CNT_W'(1);
      end
      SQ_HOLD: nextState = SQ_IDLE;
      default: nextState = SQ_IDLE;
    endcase
  end

  always_comb begin
    ctl.progSel   = (nextState != SQ_IDLE) && nxtProg;
    ctl.dataSel   = (nextState != SQ_IDLE) && !nxtProg;
    ctl.rdStb     = (nextState == SQ_STROBE) && !nxtWrite;
    ctl.wrStb     = (nextState == SQ_STROBE) && nxtWrite;
    ctl.driveBus  = (nextState != SQ_IDLE) && nxtWrite;
    ctl.latchReq  = accept;
    ctl.captureRd = (state == SQ_STROBE) && (nextState == SQ_HOLD) && !isWrite;
    ctl.ready     = (nextState == SQ_HOLD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SQ_IDLE;
      isWrite <= 1'b0;
      isProg  <= 1'b0;
      waitCnt <= '0;
    end else begin
      state   <= nextState;
      isWrite <= nxtWrite;
      isProg  <= nxtProg;
      waitCnt <= nxtCnt;
    end
  end

endmodule

// File: rtl/xmem_path.sv
module xmem_path
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic              progSelN,
  output logic              dataSelN,
  output logic              rdStrobeN,
  output logic              wrStrobeN,
  output logic              reqReady,
  output logic [DATA_W-1:0] rspRdata
);

  // Address and write data: loaded once per access, held until the next.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAddr    <= '0;
      busDataOut <= '0;
    end else if (ctl.latchReq) begin
      busAddr    <= reqAddr;
      busDataOut <= reqWdata;
    end
  end

  // Registered pin controls, so the pads see no decode glitches.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progSelN  <= 1'b1;
      dataSelN  <= 1'b1;
      rdStrobeN <= 1'b1;
      wrStrobeN <= 1'b1;
      busDataOe <= 1'b0;
      reqReady  <= 1'b0;
    end else begin
      progSelN  <= ~ctl.progSel;
      dataSelN  <= ~ctl.dataSel;
      rdStrobeN <= ~ctl.rdStb;
      wrStrobeN <= ~ctl.wrStb;
      busDataOe <= ctl.driveBus;
      reqReady  <= ctl.ready;
    end
  end

  // Read capture on the edge that raises the read strobe.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rspRdata <= '0;
    else if (ctl.captureRd) rspRdata <= busDataIn;
  end

endmodule

// File: rtl/xmem_bridge.sv
module xmem_bridge
  import xmem_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int WSEL_W    = 2,
  parameter int WAIT_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqProgSpace,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [WSEL_W-1:0] waitSel,
  output logic              reqReady,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              progSelN,
  output logic              dataSelN,
  output logic              rdStrobeN,
  output logic              wrStrobeN
);

  busCtl_t ctl;

  xmem_seq #(
    .WSEL_W   (WSEL_W),
    .WAIT_STEP(WAIT_STEP)
  ) seq_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .reqProgSpace(reqProgSpace),
    .waitSel     (waitSel),
    .ctl         (ctl)
  );

  xmem_path #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) path_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .busDataIn (busDataIn),
    .busAddr   (busAddr),
    .busDataOut(busDataOut),
    .busDataOe (busDataOe),
    .progSelN  (progSelN),
    .dataSelN  (dataSelN),
    .rdStrobeN (rdStrobeN),
    .wrStrobeN (wrStrobeN),
    .reqReady  (reqReady),
    .rspRdata  (rspRdata)
  );

endmodule

// File: rtl/xmem_bridge_chk.sv
module xmem_bridge_chk #(
  parameter int ADDR_W    = 16,
  parameter int WSEL_W    = 2,
  parameter int WAIT_STEP = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busDataOe,
  input logic              progSelN,
  input logic              dataSelN,
  input logic              rdStrobeN,
  input logic              wrStrobeN
);

  localparam int MAX_LOW = 1 + ((2 ** WSEL_W) - 1) * WAIT_STEP;
  localparam int RUN_W   = $clog2(MAX_LOW + 2) + 1;

  logic             stbActive;
  logic [RUN_W-1:0] lowRun;

  assign stbActive = !rdStrobeN || !wrStrobeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          lowRun <= '0;
    else if (stbActive) lowRun <= lowRun + RUN_W'(1);
    else                lowRun <= '0;
  end

  AST_ONE_SPACE: assert property (@(posedge clk) disable iff (!rstN)
    !(!progSelN && !dataSelN)); // R2

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdStrobeN && !wrStrobeN)); // R4

  AST_SEL_COVERS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    stbActive |-> (!progSelN || !dataSelN)); // R3

  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (stbActive && $past(!progSelN || !dataSelN)) |-> $stable(busAddr)); // R3

  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobeN |-> !busDataOe); // R5

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (progSelN && dataSelN) |-> !busDataOe); // R8

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> !reqReady); // R7

  AST_READY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!stbActive && $past(stbActive))); // R7

  AST_STROBE_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stbActive) |-> ((int'(lowRun) <= MAX_LOW) &&
                          ((int'(lowRun) - 1) % WAIT_STEP == 0))); // R6

endmodule

bind xmem_bridge xmem_bridge_chk #(
  .ADDR_W   (ADDR_W),
  .WSEL_W   (WSEL_W),
  .WAIT_STEP(WAIT_STEP)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .busAddr  (busAddr),
  .busDataOe(busDataOe),
  .progSelN (progSelN),
  .dataSelN (dataSelN),
  .rdStrobeN(rdStrobeN),
  .wrStrobeN(wrStrobeN)
);

// File: tb/xmem_bridge_tb_top.sv
module xmem_bridge_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic        reqProgSpace = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  waitSel = '0;
  logic        reqReady;
  logic [15:0] rspRdata;
  logic [15:0] busAddr;
  logic [15:0] busDataOut;
  logic        busDataOe;
  logic [15:0] busDataIn;
  logic        progSelN, dataSelN, rdStrobeN, wrStrobeN;

  int errors = 0;
  int checks = 0;

  // Space index: 1 = program, 0 = data
  logic [15:0] modelMem [2][256];
  logic [15:0] expMem   [2][256];

  always #5 clk = ~clk;

  xmem_bridge dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqProgSpace(reqProgSpace), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .waitSel(waitSel), .reqReady(reqReady), .rspRdata(rspRdata),
    .busAddr(busAddr), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .busDataIn(busDataIn), .progSelN(progSelN), .dataSelN(dataSelN),
    .rdStrobeN(rdStrobeN), .wrStrobeN(wrStrobeN)
  );

  // Asynchronous SRAM model: answers only while read strobe is low.
  assign busDataIn = !rdStrobeN ? modelMem[progSelN ? 0 : 1][busAddr[7:0]] : 16'hBAD0;

  always @(posedge wrStrobeN)
    if (rstN === 1'b1 && busDataOe === 1'b1)
      modelMem[progSelN ? 0 : 1][busAddr[7:0]] = busDataOut;

  function automatic int waitCycles(input logic [1:0] code);
    return int'(code) * 4;
  endfunction

  function automatic logic [15:0] seedWord(input int sp, input int idx);
    return 16'((sp * 16'h5A5A) ^ (idx * 16'h0137) ^ 16'h1F2E);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Called at a negedge with the DUT idle; returns at the idle negedge after ready.
  task automatic runAccess(input bit wr, input bit prog, input logic [15:0] a,
                           input logic [15:0] d, input logic [1:0] ws);
    int  cycles = 1;
    int  lowCnt = 0;
    bit  selOk = 1, addrOk = 1, oeOk = 1, dataOk = 1, otherOk = 1, timedOut = 0;
    int  sp = prog ? 1 : 0;
    logic [15:0] expRd = expMem[sp][a[7:0]];
    reqValid = 1'b1; reqWrite = wr; reqProgSpace = prog;
    reqAddr = a; reqWdata = d; waitSel = ws;
    @(negedge clk);
    reqValid = 1'b0;
    waitSel = 2'($urandom); reqAddr = 16'($urandom); reqWdata = 16'($urandom);
    reqWrite = 1'($urandom); reqProgSpace = 1'($urandom);
    forever begin
      if (prog ? (progSelN !== 1'b0 || dataSelN !== 1'b1)
               : (dataSelN !== 1'b0 || progSelN !== 1'b1)) selOk = 0;
      if (busAddr !== a) addrOk = 0;
      if (busDataOe !== wr) oeOk = 0;
      if (wr && busDataOut !== d) dataOk = 0;
      if (wr ? (rdStrobeN !== 1'b1) : (wrStrobeN !== 1'b1)) otherOk = 0;
      if (wr ? !wrStrobeN : !rdStrobeN) lowCnt++;
      if (reqReady === 1'b1) break;
      if (cycles >= 64) begin timedOut = 1; break; end
      @(negedge clk);
      cycles++;
    end
    check(!timedOut, "R7 ready never came", cycles, waitCycles(ws) + 3);
    check(selOk, "R2 space select", {progSelN, dataSelN}, prog ? 1 : 2);
    check(addrOk, "R3 address held", busAddr, a);
    check(otherOk, wr ? "R4 read strobe idle on write" : "R5 write strobe idle on read",
          {rdStrobeN, wrStrobeN}, wr ? 2 : 1);
    if (wr) begin
      check(oeOk, "R4 bus driven on write", busDataOe, 1);
      check(dataOk, "R4 write data", busDataOut, d);
    end else begin
      check(oeOk, "R5 bus released on read", busDataOe, 0);
    end
    check(lowCnt == 1 + waitCycles(ws), "R6 strobe length", lowCnt, 1 + waitCycles(ws));
    check(cycles == waitCycles(ws) + 3, "R7 latency", cycles, waitCycles(ws) + 3);
    check(rdStrobeN === 1'b1 && wrStrobeN === 1'b1, "R7 strobes high at ready",
          {rdStrobeN, wrStrobeN}, 3);
    if (wr) expMem[sp][a[7:0]] = d;
    else check(rspRdata === expRd, "R5 read data", rspRdata, expRd);
    @(negedge clk);
    check(reqReady === 1'b0, "R7 ready single cycle", reqReady, 0);
    check(progSelN === 1'b1 && dataSelN === 1'b1 && busDataOe === 1'b0,
          "R8 released when idle", {progSelN, dataSelN, busDataOe}, 6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 256; i++) begin
        modelMem[s][i] = seedWord(s, i);
        expMem[s][i]   = seedWord(s, i);
      end
    repeat (3) @(negedge clk);
    check(progSelN === 1'b1 && dataSelN === 1'b1 && rdStrobeN === 1'b1 &&
          wrStrobeN === 1'b1 && busDataOe === 1'b0 && reqReady === 1'b0,
          "R1 reset state", {progSelN, dataSelN, rdStrobeN, wrStrobeN, busDataOe, reqReady}, 6'b111100);
    rstN = 1'b1;
    @(negedge clk);
    check(progSelN === 1'b1 && dataSelN === 1'b1 && busDataOe === 1'b0,
          "R1 after reset", {progSelN, dataSelN, busDataOe}, 6);

    // Directed: every wait code, both spaces, address extremes (R6, R2, R3)
    for (int w = 0; w < 4; w++) begin
      runAccess(1, 1, 16'h0000, 16'hA000 + 16'(w), 2'(w));
      runAccess(1, 0, 16'h0000, 16'h5000 + 16'(w), 2'(w));
      runAccess(0, 1, 16'h0000, 16'h0, 2'(w));
      runAccess(0, 0, 16'h0000, 16'h0, 2'(w));
      runAccess(1, 0, 16'hFFFF, 16'hC3C3 ^ 16'(w), 2'(w));
      runAccess(0, 0, 16'hFFFF, 16'h0, 2'(w));
    end

    // Random mix: back-to-back and with idle gaps (R9)
    for (int n = 0; n < 300; n++) begin
      int gap = int'($urandom % 4);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        check(busDataOe === 1'b0 && progSelN === 1'b1 && dataSelN === 1'b1,
              "R8 idle gap", {progSelN, dataSelN, busDataOe}, 6);
      end
      runAccess(1'($urandom), 1'($urandom), {8'($urandom), 8'($urandom % 16)},
                16'($urandom), 2'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule